// File: doc/BRIEF.md
# DDR2 On-Die Termination Controller

This block models, cycle by cycle, the logic inside a DDR2 memory device that switches the on-die termination of the data and strobe pins. A write to extended mode register 1 sets the nominal termination resistance. The block watches the termination request pin, the clock-enable pin and a self-refresh indication. It then drives one termination enable and a resistance code. These change after a delay that depends on the device's power state.

Two latency sets are used. One applies while the device is awake (active or standby). The other, slower set applies while it is powered down. An edge on the request pin that comes just before power-down entry, or too soon after power-down exit, is timed with the slower set. While self-refresh is active, termination is held off.

Top module: `ddr2_odt_ctrl`

## Requirements
- R1: A mode-register write to bank code 3'b001 captures the pair {addr[6], addr[2]} as the termination code. While termination is on, `rtt_code` shows that pair: 2'b01 = 75 ohm, 2'b10 = 150 ohm, 2'b11 = 50 ohm. `rtt_code` is 2'b00 whenever `rtt_en` is low.
- R2: A mode-register write with any other bank code leaves the stored termination code unchanged.
- R3: Reset clears the stored code to 2'b00 (no termination) and drives `rtt_en` low.
- R4: In awake timing, the request pin is first sampled high at clock edge t. `rtt_en` then rises at edge t+T_ON_ACT (default 2).
- R5: In awake timing, the request pin is first sampled low at clock edge t. `rtt_en` then falls at edge t+T_OFF_ACT (default 3).
- R6: A request edge sampled while `cke` is low uses T_ON_PD / T_OFF_PD (default 4 each).
- R7: A pending edge sampled fewer than T_PD_ENTRY (default 3) edges before the edge where `cke` is first sampled low switches to power-down timing. An edge sampled T_PD_ENTRY or more edges before keeps awake timing.
- R8: After `cke` is first sampled high at edge r, a request edge at edge t uses power-down timing when t-r < T_PD_EXIT (default 6). It uses awake timing when t-r >= T_PD_EXIT.
- R9: At every edge where `selfref` is sampled high, termination is switched off and any pending change is dropped. Request-pin activity during self-refresh never turns termination on.
- R10: An opposite request edge that arrives before a pending change completes cancels that change. The new edge starts its own full delay.
- R11: With the stored code 2'b00, `rtt_en` stays low whatever the request pin does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| cke | input | 1 | Clock enable; low means power-down |
| odt | input | 1 | Termination request pin |
| selfref | input | 1 | High while the device is in self-refresh |
| emr_wr | input | 1 | Mode-register write strobe |
| emr_ba | input | 3 | Bank address of the mode-register write |
| emr_addr | input | ADDR_W | Address bus of the mode-register write |
| rtt_en | output | 1 | Termination enable shared by DQ, DQS, /DQS, RDQS, /RDQS |
| rtt_code | output | 2 | Active resistance code, 2'b00 when off |

## Verification
The bench targets request edges placed one cycle and several cycles before power-down entry. A design that judges timing only when the edge arrives would switch termination too early in the first case. It also drives edges two and seven cycles after wake-up, where an off-by-one in the exit window counter picks the wrong latency set. Back-to-back opposite edges check cancellation; a design that lets the stale change finish would flash termination on. A self-refresh episode with request activity, and a write to the wrong bank, check that ignored inputs leave `rtt_en` and `rtt_code` untouched.

// File: rtl/ddr2_odt_pkg.sv
package ddr2_odt_pkg;

    typedef enum logic [1:0] {
        RTT_NONE = 2'b00,
        RTT_75   = 2'b01,
        RTT_150  = 2'b10,
        RTT_50   = 2'b11
    } rtt_sel_e;

    // Pending termination change
    typedef struct packed {
        logic live;   // change in flight
        logic dir;    // level to apply
        logic pd;     // slow (power-down) latency set
    } odt_pend_t;

    localparam logic [2:0] EMR1_BANK = 3'b001;

    function automatic rtt_sel_e rtt_from_addr(input logic hi_bit, input logic lo_bit);
        return rtt_sel_e'({hi_bit, lo_bit});
    endfunction

endpackage

// File: rtl/odt_emr_decode.sv
module odt_emr_decode
    import ddr2_odt_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emr_wr,
    input  logic [2:0]        emr_ba,
    input  logic [ADDR_W-1:0] emr_addr,
    output rtt_sel_e          rtt_sel
);

    logic hit;
    logic addr_unused;

    assign hit = emr_wr && (emr_ba == EMR1_BANK);
    assign addr_unused = ^{emr_addr[ADDR_W-1:7], emr_addr[5:3], emr_addr[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rtt_sel <= RTT_NONE;
        end else if (hit) begin
            rtt_sel <= rtt_from_addr(emr_addr[6], emr_addr[2]);
        end
    end

    // R1
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (rtt_sel == rtt_sel_e'({$past(emr_addr[6]), $past(emr_addr[2])})));

    // R2
    other_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (emr_wr && emr_ba != EMR1_BANK) |=> $stable(rtt_sel));

endmodule

// File: rtl/odt_pd_track.sv
module odt_pd_track #(
    parameter int unsigned T_PD_EXIT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    output logic cke_fall,
    output logic slow_timing
);

    localparam int unsigned XW = $clog2(T_PD_EXIT + 1) + 1;
    localparam logic [XW-1:0] XMAX = XW'(T_PD_EXIT);

    logic          cke_q;
    logic [XW-1:0] xage;   // edges since the last low sample, saturating

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b1;
            xage  <= XMAX;
        end else begin
            cke_q <= cke;
            if (!cke) begin
                xage <= '0;
            end else if (xage < XMAX) begin
                xage <= xage + 1'b1;
            end
        end
    end

    assign cke_fall    = cke_q & ~cke;
    assign slow_timing = ~cke | (xage < XMAX);

    // R8
    wake_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> slow_timing);

endmodule

// File: rtl/odt_sched.sv
module odt_sched
    import ddr2_odt_pkg::*;
#(
    parameter int unsigned T_ON_ACT   = 2,
    parameter int unsigned T_OFF_ACT  = 3,
    parameter int unsigned T_ON_PD    = 4,
    parameter int unsigned T_OFF_PD   = 4,
    parameter int unsigned T_PD_ENTRY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic selfref,
    input  logic odt,
    input  logic cke_fall,
    input  logic slow_timing,
    output logic term_on
);

    localparam int unsigned MAX_A = (T_ON_ACT > T_OFF_ACT) ? T_ON_ACT : T_OFF_ACT;
    localparam int unsigned MAX_P = (T_ON_PD > T_OFF_PD) ? T_ON_PD : T_OFF_PD;
    localparam int unsigned MAXD  = (MAX_A > MAX_P) ? MAX_A : MAX_P;
    localparam int unsigned TOP   = (MAXD > T_PD_ENTRY) ? MAXD : T_PD_ENTRY;
    localparam int unsigned AW    = $clog2(TOP + 1) + 1;
    localparam logic [AW-1:0] ENTRY_C = AW'(T_PD_ENTRY);
    localparam logic [AW-1:0] MAXD_C  = AW'(MAXD);

    function automatic logic [AW-1:0] latency(input logic dir, input logic pd);
        case ({dir, pd})
            2'b10:   return AW'(T_ON_ACT);
            2'b11:   return AW'(T_ON_PD);
            2'b00:   return AW'(T_OFF_ACT);
            default: return AW'(T_OFF_PD);
        endcase
    endfunction

    odt_pend_t     pend;
    logic [AW-1:0] age;
    logic          odt_q;
    logic          odt_edge;
    logic          eff_pd;
    logic          done;

    assign odt_edge = odt ^ odt_q;
    assign eff_pd   = pend.pd | (cke_fall & (age < ENTRY_C));
    assign done     = pend.live & (age == latency(pend.dir, eff_pd));

    always_ff @(posedge clk) begin
        if (rst) begin
            odt_q   <= 1'b0;
            pend    <= '0;
            age     <= '0;
            term_on <= 1'b0;
        end else begin
            odt_q <= odt;
            if (selfref) begin
                term_on <= 1'b0;
                pend    <= '0;
            end else begin
                if (pend.live) begin
                    pend.pd <= eff_pd;
                    if (done) begin
                        term_on   <= pend.dir;
                        pend.live <= 1'b0;
                    end else begin
                        age <= age + 1'b1;
                    end
                end
                if (odt_edge) begin
                    pend <= '{live: 1'b1, dir: odt, pd: slow_timing};
                    age  <= AW'(1);
                end
            end
        end
    end

    // R9
    selfref_off_chk: assert property (@(posedge clk) disable iff (rst)
        selfref |=> !term_on);

    // R4
    change_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(term_on) && !$past(selfref)) |-> $past(pend.live));

    // R6
    age_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pend.live |-> (age <= MAXD_C));

endmodule

// File: rtl/ddr2_odt_ctrl.sv
module ddr2_odt_ctrl
    import ddr2_odt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned T_ON_ACT   = 2,
    parameter int unsigned T_OFF_ACT  = 3,
    parameter int unsigned T_ON_PD    = 4,
    parameter int unsigned T_OFF_PD   = 4,
    parameter int unsigned T_PD_ENTRY = 3,
    parameter int unsigned T_PD_EXIT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              odt,
    input  logic              selfref,
    input  logic              emr_wr,
    input  logic [2:0]        emr_ba,
    input  logic [ADDR_W-1:0] emr_addr,
    output logic              rtt_en,
    output logic [1:0]        rtt_code
);

    rtt_sel_e rtt_sel;
    logic     cke_fall;
    logic     slow_timing;
    logic     term_on;

    odt_emr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .emr_wr   (emr_wr),
        .emr_ba   (emr_ba),
        .emr_addr (emr_addr),
        .rtt_sel  (rtt_sel)
    );

    odt_pd_track #(.T_PD_EXIT(T_PD_EXIT)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .cke         (cke),
        .cke_fall    (cke_fall),
        .slow_timing (slow_timing)
    );

    odt_sched #(
        .T_ON_ACT   (T_ON_ACT),
        .T_OFF_ACT  (T_OFF_ACT),
        .T_ON_PD    (T_ON_PD),
        .T_OFF_PD   (T_OFF_PD),
        .T_PD_ENTRY (T_PD_ENTRY)
    ) u_sch (
        .clk         (clk),
        .rst         (rst),
        .selfref     (selfref),
        .odt         (odt),
        .cke_fall    (cke_fall),
        .slow_timing (slow_timing),
        .term_on     (term_on)
    );

    assign rtt_en   = term_on && (rtt_sel != RTT_NONE);
    assign rtt_code = rtt_en ? rtt_sel : RTT_NONE;

endmodule

// File: tb/ddr2_odt_ctrl_test.sv
`timescale 1ns/1ps
module ddr2_odt_ctrl_test;

    localparam int T_ON_ACT = 2, T_OFF_ACT = 3, T_ON_PD = 4, T_OFF_PD = 4;
    localparam int T_PD_ENTRY = 3, T_PD_EXIT = 6;

    logic clk = 1'b0;
    logic rst = 1'b1, cke = 1'b1, odt = 1'b0, selfref = 1'b0, emr_wr = 1'b0;
    logic [2:0]  emr_ba = '0;
    logic [13:0] emr_addr = '0;
    logic rtt_en;
    logic [1:0] rtt_code;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R3";

    always #2.5 clk = ~clk;

    ddr2_odt_ctrl #(
        .ADDR_W(14), .T_ON_ACT(T_ON_ACT), .T_OFF_ACT(T_OFF_ACT), .T_ON_PD(T_ON_PD),
        .T_OFF_PD(T_OFF_PD), .T_PD_ENTRY(T_PD_ENTRY), .T_PD_EXIT(T_PD_EXIT)
    ) uut (
        .clk(clk), .rst(rst), .cke(cke), .odt(odt), .selfref(selfref),
        .emr_wr(emr_wr), .emr_ba(emr_ba), .emr_addr(emr_addr),
        .rtt_en(rtt_en), .rtt_code(rtt_code)
    );

    // Behavioural reference, advanced at each rising edge
    int  cyc = 0, p_start = 0, last_low = -1000;
    bit  m_term, p_act, p_dir, p_pd, m_odt, m_cke = 1'b1, started;
    bit  [1:0] m_code;

    always @(posedge clk) begin
        bit cfall, pd_new;
        int age, need;
        if (rst) begin
            m_code = 0; m_term = 0; p_act = 0; p_dir = 0; p_pd = 0;
            m_odt = 0; m_cke = 1; last_low = -1000;
        end else begin
            cfall  = m_cke && !cke;
            pd_new = !cke || ((cyc - last_low - 1) < T_PD_EXIT);
            if (selfref) begin
                m_term = 0; p_act = 0;
            end else begin
                if (p_act) begin
                    age = cyc - p_start;
                    if (cfall && age < T_PD_ENTRY) p_pd = 1;
                    need = p_dir ? (p_pd ? T_ON_PD : T_ON_ACT) : (p_pd ? T_OFF_PD : T_OFF_ACT);
                    if (age == need) begin
                        m_term = p_dir; p_act = 0;
                    end
                end
                if (odt != m_odt) begin
                    p_act = 1; p_dir = odt; p_start = cyc; p_pd = pd_new;
                end
            end
            if (emr_wr && emr_ba == 3'b001) m_code = {emr_addr[6], emr_addr[2]};
            if (!cke) last_low = cyc;
            m_odt = odt; m_cke = cke;
        end
        cyc++;
        started = 1'b1;
    end

    // Compare against the reference on every clock
    always @(negedge clk) begin
        bit  exp_en;
        bit  [1:0] exp_code;
        if (started) begin
            exp_en   = m_term && (m_code != 2'b00);
            exp_code = exp_en ? m_code : 2'b00;
            checks++;
            if (rtt_en !== exp_en || rtt_code !== exp_code) begin
                errors++;
                $display("FAIL %s cycle %0d: rtt_en=%0b rtt_code=%02b expected rtt_en=%0b rtt_code=%02b",
                         cur_req, cyc, rtt_en, rtt_code, exp_en, exp_code);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02b expected %02b", req, act, exp);
        end
    endtask

    task automatic emr(input logic [2:0] ba, input logic a6, input logic a2);
        emr_wr = 1'b1; emr_ba = ba; emr_addr = 14'h3fff;
        emr_addr[6] = a6; emr_addr[2] = a2;
        tick(1);
        emr_wr = 1'b0; emr_addr = '0; emr_ba = '0;
    endtask

    initial begin
        tick(3);
        chk("R3", {1'b0, rtt_en}, 2'b00);
        chk("R3", rtt_code, 2'b00);
        rst = 1'b0;
        tick(1);

        cur_req = "R1"; emr(3'b001, 1'b0, 1'b1);
        cur_req = "R4"; odt = 1; tick(5);
        chk("R1", rtt_code, 2'b01);
        cur_req = "R5"; odt = 0; tick(6);

        cur_req = "R2"; emr(3'b000, 1'b1, 1'b0); emr(3'b101, 1'b1, 1'b1);
        odt = 1; tick(4);
        chk("R2", rtt_code, 2'b01);
        odt = 0; tick(6);

        cur_req = "R1"; emr(3'b001, 1'b1, 1'b0);
        odt = 1; tick(4);
        chk("R1", rtt_code, 2'b10);
        emr(3'b001, 1'b1, 1'b1); tick(1);
        chk("R1", rtt_code, 2'b11);
        odt = 0; tick(6);

        cur_req = "R6"; cke = 0; tick(3);
        odt = 1; tick(6); odt = 0; tick(6);
        cke = 1; tick(8);

        cur_req = "R7"; odt = 1; tick(1); cke = 0; tick(8);
        cke = 1; tick(8); odt = 0; tick(8);
        odt = 1; tick(4); cke = 0; tick(6);
        cke = 1; tick(8); odt = 0; tick(8);
        odt = 0; tick(1); odt = 1; tick(2); cke = 0; tick(6);
        odt = 0; tick(6); cke = 1; tick(8);

        cur_req = "R8"; cke = 0; tick(3); cke = 1; tick(2);
        odt = 1; tick(8); odt = 0; tick(8);
        cke = 0; tick(2); cke = 1; tick(7);
        odt = 1; tick(6); odt = 0; tick(6);

        cur_req = "R10"; odt = 1; tick(1); odt = 0; tick(1); odt = 1; tick(6);
        odt = 0; tick(2); odt = 1; tick(6);
        odt = 0; tick(6);

        cur_req = "R9"; odt = 1; tick(6);
        selfref = 1; cke = 0; tick(2);
        odt = 0; tick(2); odt = 1; tick(5);
        chk("R9", {1'b0, rtt_en}, 2'b00);
        selfref = 0; cke = 1; tick(8);
        chk("R9", {1'b0, rtt_en}, 2'b00);
        odt = 0; tick(6);

        cur_req = "R11"; emr(3'b001, 1'b0, 1'b0);
        odt = 1; tick(6);
        chk("R11", {1'b0, rtt_en}, 2'b00);
        odt = 0; tick(6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule